// File: doc/BRIEF.md
# Programmable Chip Select Decoder

This block turns a 28-bit processor address into one of eight active-low chip selects for ROM and I/O banks. It also paces every bus cycle it claims. Each bank holds a configuration word with an enable bit, a base address, a 3-bit size code and two sets of timing, one for reads and one for writes. Each timing set gives four phase lengths counted in clocks: setup, access, hold and recovery. Several banks may match one address. The lowest-numbered bank then wins. An address that no enabled bank claims gets no select and no acknowledge.

The processor raises `bus_req` with a stable address and direction and holds it until it sees `bus_ack`. The block asserts the bank select first, then the read or write strobe, and then raises the internal acknowledge in the last clock of the strobe. After that it keeps the select for the hold phase, releases the bank, and blocks the same bank for the recovery count. A configuration word is written in one clock through `cfg_we`, `cfg_bank` and `cfg_wdata`. After reset only bank 0 answers, as an 8 Mbyte boot region at address zero.

Top module: `cs_decoder`

## Requirements
- R1: After reset all selects and strobes are high (inactive) and `bus_ack` is low. Bank 0 is enabled with size code 5 (8 Mbytes) at base 0, with setup 1, access 4, hold 1 and recovery 1 for both reads and writes. Banks 1 to 7 are disabled.
- R2: `cfg_wdata` is laid out as: bit 37 enable; bits 36:34 size code; bits 33:24 base (address bits 27:18); bits 23:12 read timing; bits 11:0 write timing. Each timing field is {setup[11:9], access[8:6], hold[5:3], recovery[2:0]} relative to its 12-bit group. Size code k selects 2^(18+k) bytes for k = 0..6, and code 7 selects 64 Mbytes. Only the address bits above the bank size are compared with the base.
- R3: When several enabled banks match an address, only the lowest-numbered one is selected.
- R4: A request whose address matches no enabled bank produces no chip select and no acknowledge for as long as it is held.
- R5: At the start of a cycle the bank select is low for exactly `setup` clocks before the strobe goes low.
- R6: The strobe stays low for max(access, 1) clocks. `bus_ack` is high for exactly one clock, the last clock of the strobe.
- R7: After the strobe rises, the select stays low for exactly `hold` clocks.
- R8: A read drives only `rd_n` and uses the read timing. A write drives only `wr_n` and uses the write timing.
- R9: Between two cycles to the same bank, that bank's select stays high for at least recovery + 1 clocks.
- R10: A new cycle starts only after `bus_req` has been low for at least one clock. A request held after its acknowledge does not start a second cycle.
- R11: At most one chip select is low at any time, and the active select does not change in the middle of a cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Writes `cfg_wdata` into the selected bank's configuration |
| cfg_bank | input | 3 | Bank number for the configuration write |
| cfg_wdata | input | 38 | Configuration word (layout in R2) |
| bus_req | input | 1 | Processor cycle request, held until acknowledged |
| bus_wr | input | 1 | 1 = write cycle, 0 = read cycle |
| bus_addr | input | 28 | Processor byte address |
| cs_n | output | 8 | Active-low bank selects |
| rd_n | output | 1 | Active-low read strobe |
| wr_n | output | 1 | Active-low write strobe |
| bus_ack | output | 1 | Internal data acknowledge, one clock |

## Verification
The main function is exercised with four kinds of address pattern. Addresses at the first and last byte of a bank, and one byte past the end, separate the size decode from the base compare. Addresses inside overlapping banks show whether the priority order is right. Addresses outside every enabled bank, including a bank that has just been disabled, show that a miss stays silent. The timing is tried with a zero setup and zero access, with a long write profile that differs from the read profile, and with a large recovery count on back-to-back requests. Together these separate the phase counts from one another and from the read/write choice.

// File: rtl/cs_pkg.sv
package cs_pkg;

    parameter int NUM_BANKS    = 8;
    parameter int ADDR_W       = 28;
    parameter int BASE_LSB     = 18;   // smallest bank is 2^BASE_LSB bytes
    parameter int SZ_W         = 3;
    parameter int PH_W         = 3;
    parameter int LARGEST_LOG2 = 26;   // span selected by the top size code

    localparam int BANK_W = $clog2(NUM_BANKS);
    localparam int BASE_W = ADDR_W - BASE_LSB;

    typedef struct packed {
        logic [PH_W-1:0] setup;
        logic [PH_W-1:0] access;
        logic [PH_W-1:0] hold;
        logic [PH_W-1:0] recov;
    } phase_t;

    typedef struct packed {
        logic            en;
        logic [SZ_W-1:0] size;
        logic [BASE_W-1:0] base;
        phase_t          rd;
        phase_t          wr;
    } bank_cfg_t;

    localparam int CFG_W = $bits(bank_cfg_t);

    typedef enum logic [1:0] {
        PH_IDLE,
        PH_SETUP,
        PH_ACCESS,
        PH_HOLD
    } cyc_state_t;

    // Mask of the base bits that take part in the compare for a size code.
    function automatic logic [BASE_W-1:0] span_mask(input logic [SZ_W-1:0] code);
        int unsigned ign;
        logic [BASE_W-1:0] m;
        if (code == {SZ_W{1'b1}})
            ign = LARGEST_LOG2 - BASE_LSB;
        else
            ign = int'(code);
        m = '1;
        m = m << ign;
        return m;
    endfunction

    // Access phase length minus one, with the length floored at one clock.
    function automatic logic [PH_W-1:0] access_m1(input logic [PH_W-1:0] a);
        return (a == '0) ? '0 : a - 1'b1;
    endfunction

    function automatic bank_cfg_t boot_cfg();
        bank_cfg_t c;
        c.en     = 1'b1;
        c.size   = SZ_W'(5);
        c.base   = '0;
        c.rd     = '{setup: PH_W'(1), access: PH_W'(4), hold: PH_W'(1), recov: PH_W'(1)};
        c.wr     = c.rd;
        return c;
    endfunction

endpackage

// File: rtl/cs_bank_regs.sv
module cs_bank_regs
    import cs_pkg::*;
(
    input  logic                              clk,
    input  logic                              rst,
    input  logic                              cfg_we,
    input  logic [BANK_W-1:0]                 cfg_bank,
    input  logic [CFG_W-1:0]                  cfg_wdata,
    output bank_cfg_t [NUM_BANKS-1:0]         cfg_o
);

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NUM_BANKS; i++)
                cfg_o[i] <= (i == 0) ? boot_cfg() : '0;
        end else if (cfg_we) begin
            cfg_o[cfg_bank] <= bank_cfg_t'(cfg_wdata);
        end
    end

endmodule

// File: rtl/cs_addr_match.sv
module cs_addr_match
    import cs_pkg::*;
(
    input  bank_cfg_t [NUM_BANKS-1:0] cfg_i,
    input  logic [ADDR_W-1:0]         addr,
    output logic                      hit,
    output logic [BANK_W-1:0]         hit_idx
);

    logic [NUM_BANKS-1:0] bank_hit;

    for (genvar g = 0; g < NUM_BANKS; g++) begin : g_cmp
        assign bank_hit[g] = cfg_i[g].en &&
            (((addr[ADDR_W-1:BASE_LSB] ^ cfg_i[g].base) & span_mask(cfg_i[g].size)) == '0);
    end

    // Scan downward so the lowest-numbered matching bank is the one kept.
    always_comb begin
        hit     = 1'b0;
        hit_idx = '0;
        for (int i = NUM_BANKS - 1; i >= 0; i--) begin
            if (bank_hit[i]) begin
                hit     = 1'b1;
                hit_idx = BANK_W'(i);
            end
        end
    end

endmodule

// File: rtl/cs_cycle_seq.sv
module cs_cycle_seq
    import cs_pkg::*;
(
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      bus_req,
    input  logic                      bus_wr,
    input  logic                      hit,
    input  logic [BANK_W-1:0]         hit_idx,
    input  bank_cfg_t [NUM_BANKS-1:0] cfg_i,
    output logic [NUM_BANKS-1:0]      cs_n,
    output logic                      rd_n,
    output logic                      wr_n,
    output logic                      ack
);

    cyc_state_t        st;
    logic [BANK_W-1:0] cur;
    phase_t            ph;
    logic              cur_wr;
    logic [PH_W-1:0]   cnt;
    logic              armed;
    logic [PH_W-1:0]   rec_cnt [NUM_BANKS];

    phase_t sel_ph;
    logic   start;
    logic   last;
    logic   finish;

    assign sel_ph = bus_wr ? cfg_i[hit_idx].wr : cfg_i[hit_idx].rd;
    assign start  = (st == PH_IDLE) && bus_req && armed && hit && (rec_cnt[hit_idx] == '0);
    assign last   = (cnt == '0);
    assign finish = ((st == PH_ACCESS) && last && (ph.hold == '0)) ||
                    ((st == PH_HOLD) && last);

    always_ff @(posedge clk) begin
        if (rst) begin
            st     <= PH_IDLE;
            cur    <= '0;
            ph     <= '0;
            cur_wr <= 1'b0;
            cnt    <= '0;
            armed  <= 1'b1;
        end else begin
            if (start)
                armed <= 1'b0;
            else if (!bus_req)
                armed <= 1'b1;

            unique case (st)
                PH_IDLE: begin
                    if (start) begin
                        cur    <= hit_idx;
                        ph     <= sel_ph;
                        cur_wr <= bus_wr;
                        if (sel_ph.setup != '0) begin
                            st  <= PH_SETUP;
                            cnt <= sel_ph.setup - 1'b1;
                        end else begin
                            st  <= PH_ACCESS;
                            cnt <= access_m1(sel_ph.access);
                        end
                    end
                end
                PH_SETUP: begin
                    if (last) begin
                        st  <= PH_ACCESS;
                        cnt <= access_m1(ph.access);
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                PH_ACCESS: begin
                    if (last) begin
                        if (ph.hold != '0) begin
                            st  <= PH_HOLD;
                            cnt <= ph.hold - 1'b1;
                        end else begin
                            st <= PH_IDLE;
                        end
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                PH_HOLD: begin
                    if (last)
                        st <= PH_IDLE;
                    else
                        cnt <= cnt - 1'b1;
                end
                default: st <= PH_IDLE;
            endcase
        end
    end

    // Per-bank recovery counters: loaded when a cycle to that bank ends.
    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NUM_BANKS; i++)
                rec_cnt[i] <= '0;
        end else begin
            for (int i = 0; i < NUM_BANKS; i++) begin
                if (finish && (cur == BANK_W'(i)))
                    rec_cnt[i] <= ph.recov;
                else if (rec_cnt[i] != '0)
                    rec_cnt[i] <= rec_cnt[i] - 1'b1;
            end
        end
    end

    always_comb begin
        cs_n = '1;
        if (st != PH_IDLE)
            cs_n[cur] = 1'b0;
    end

    assign rd_n = !((st == PH_ACCESS) && !cur_wr);
    assign wr_n = !((st == PH_ACCESS) && cur_wr);
    assign ack  = (st == PH_ACCESS) && last;

endmodule

// File: rtl/cs_decoder.sv
module cs_decoder
    import cs_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 cfg_we,
    input  logic [BANK_W-1:0]    cfg_bank,
    input  logic [CFG_W-1:0]     cfg_wdata,
    input  logic                 bus_req,
    input  logic                 bus_wr,
    input  logic [ADDR_W-1:0]    bus_addr,
    output logic [NUM_BANKS-1:0] cs_n,
    output logic                 rd_n,
    output logic                 wr_n,
    output logic                 bus_ack
);

    bank_cfg_t [NUM_BANKS-1:0] cfg;
    logic                      hit;
    logic [BANK_W-1:0]         hit_idx;

    cs_bank_regs u_regs (
        .clk       (clk),
        .rst       (rst),
        .cfg_we    (cfg_we),
        .cfg_bank  (cfg_bank),
        .cfg_wdata (cfg_wdata),
        .cfg_o     (cfg)
    );

    cs_addr_match u_match (
        .cfg_i   (cfg),
        .addr    (bus_addr),
        .hit     (hit),
        .hit_idx (hit_idx)
    );

    cs_cycle_seq u_seq (
        .clk     (clk),
        .rst     (rst),
        .bus_req (bus_req),
        .bus_wr  (bus_wr),
        .hit     (hit),
        .hit_idx (hit_idx),
        .cfg_i   (cfg),
        .cs_n    (cs_n),
        .rd_n    (rd_n),
        .wr_n    (wr_n),
        .ack     (bus_ack)
    );

endmodule

// File: rtl/cs_decoder_chk.sv
module cs_decoder_chk
    import cs_pkg::*;
(
    input logic                 clk,
    input logic                 rst,
    input logic                 bus_req,
    input logic [NUM_BANKS-1:0] cs_n,
    input logic                 rd_n,
    input logic                 wr_n,
    input logic                 bus_ack
);

    assert_reset_idle_R1: assert property (@(posedge clk)
        $past(rst) |-> (cs_n == '1 && rd_n && wr_n && !bus_ack));

    assert_one_select_R11: assert property (@(posedge clk) disable iff (rst)
        $onehot0(~cs_n));

    assert_select_steady_R11: assert property (@(posedge clk) disable iff (rst)
        (cs_n != '1 && $past(cs_n) != '1) |-> cs_n == $past(cs_n));

    assert_strobe_under_select_R5: assert property (@(posedge clk) disable iff (rst)
        (!rd_n || !wr_n) |-> cs_n != '1);

    assert_single_strobe_R8: assert property (@(posedge clk) disable iff (rst)
        !(!rd_n && !wr_n));

    assert_ack_in_strobe_R6: assert property (@(posedge clk) disable iff (rst)
        bus_ack |-> (!rd_n || !wr_n));

    assert_ack_one_clock_R6: assert property (@(posedge clk) disable iff (rst)
        bus_ack |=> !bus_ack);

    assert_start_needs_req_R10: assert property (@(posedge clk) disable iff (rst)
        ($past(cs_n) == '1 && cs_n != '1) |-> $past(bus_req));

endmodule

bind cs_decoder cs_decoder_chk chk_i (
    .clk     (clk),
    .rst     (rst),
    .bus_req (bus_req),
    .cs_n    (cs_n),
    .rd_n    (rd_n),
    .wr_n    (wr_n),
    .bus_ack (bus_ack)
);

// File: tb/cs_decoder_tb.sv
module cs_decoder_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_we = 1'b0;
    logic [2:0]  cfg_bank = '0;
    logic [37:0] cfg_wdata = '0;
    logic        bus_req = 1'b0;
    logic        bus_wr = 1'b0;
    logic [27:0] bus_addr = '0;
    logic [7:0]  cs_n;
    logic        rd_n;
    logic        wr_n;
    logic        bus_ack;

    int checks = 0;
    int fails  = 0;

    always #5 clk = ~clk;

    cs_decoder dut_i (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_bank(cfg_bank),
        .cfg_wdata(cfg_wdata), .bus_req(bus_req), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n),
        .bus_ack(bus_ack)
    );

    typedef struct {
        int bank;
        int s;
        int a;
        int h;
        bit wr;
        int min_gap;
        string req;
    } item_t;

    item_t exp_q[$];

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
        end
    endtask

    function automatic logic [37:0] mk_cfg(input bit en, input int sz, input int base_addr,
        input int rs, input int ra, input int rh, input int rr,
        input int ws, input int wa, input int wh, input int wr);
        logic [27:0] b;
        b = 28'(base_addr);
        return {en, 3'(sz), b[27:18], 3'(rs), 3'(ra), 3'(rh), 3'(rr),
                3'(ws), 3'(wa), 3'(wh), 3'(wr)};
    endfunction

    task automatic write_cfg(input int bank, input logic [37:0] w);
        @(negedge clk);
        cfg_we = 1'b1; cfg_bank = 3'(bank); cfg_wdata = w;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    // Driver: pushes the expected cycle shape, then runs one bus cycle.
    task automatic do_cycle(input int addr, input bit wr, input int bank,
                            input int s, input int a, input int h,
                            input int min_gap, input string req, input int linger);
        item_t it;
        int n;
        int extra_acks;
        it = '{bank: bank, s: s, a: (a == 0) ? 1 : a, h: h, wr: wr,
               min_gap: min_gap, req: req};
        exp_q.push_back(it);
        @(negedge clk);
        bus_addr = 28'(addr); bus_wr = wr; bus_req = 1'b1;
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (!bus_ack && n < 100);
        check(bus_ack == 1'b1, req, "acknowledge seen", int'(bus_ack), 1);
        if (linger > 0) begin
            extra_acks = 0;
            for (int k = 0; k < linger; k++) begin
                @(negedge clk);
                if (bus_ack) extra_acks++;
            end
            check(extra_acks == 0, "R10", "acks while request held", extra_acks, 0);
            check(cs_n == 8'hFF, "R10", "select while request held", int'(cs_n), 255);
        end
        bus_req = 1'b0;
    endtask

    task automatic miss_cycle(input int addr, input string req);
        int acks;
        @(negedge clk);
        bus_addr = 28'(addr); bus_wr = 1'b0; bus_req = 1'b1;
        acks = 0;
        for (int k = 0; k < 20; k++) begin
            @(negedge clk);
            if (bus_ack) acks++;
        end
        check(acks == 0, req, "ack on unmatched address", acks, 0);
        check(cs_n == 8'hFF, req, "select on unmatched address", int'(cs_n), 255);
        bus_req = 1'b0;
        @(negedge clk);
    endtask

    // Monitor: measures each select cycle at the ports and compares.
    initial begin
        int cyc;
        bit in_cyc;
        int bank, s_cnt, a_cnt, h_cnt, acks, ack_at, gap;
        bit saw_wr;
        int last_end [8];
        item_t it;
        cyc = 0; in_cyc = 0;
        bank = 0; s_cnt = 0; a_cnt = 0; h_cnt = 0; acks = 0; ack_at = 0; saw_wr = 0;
        for (int b = 0; b < 8; b++) last_end[b] = -1000;
        forever begin
            @(negedge clk);
            cyc++;
            if (!rst && cs_n != 8'hFF) begin
                int idx;
                idx = 0;
                for (int b = 7; b >= 0; b--) if (!cs_n[b]) idx = b;
                if ($countones(~cs_n) != 1)
                    check(0, "R11", "selects low at once", $countones(~cs_n), 1);
                if (!in_cyc) begin
                    in_cyc = 1; bank = idx; s_cnt = 0; a_cnt = 0; h_cnt = 0;
                    acks = 0; ack_at = 0; saw_wr = 0;
                    gap = cyc - last_end[idx];
                    if (exp_q.size() == 0) begin
                        check(0, "R4", "select with no cycle expected", idx, -1);
                    end else if (exp_q[0].min_gap > 0) begin
                        check(gap >= exp_q[0].min_gap, "R9", "recovery gap", gap,
                              exp_q[0].min_gap);
                    end
                end else if (idx != bank) begin
                    check(0, "R11", "select moved mid-cycle", idx, bank);
                end
                if (!rd_n || !wr_n) begin
                    a_cnt++;
                    if (!wr_n) saw_wr = 1;
                end else if (a_cnt == 0) begin
                    s_cnt++;
                end else begin
                    h_cnt++;
                end
                if (bus_ack) begin
                    acks++;
                    ack_at = a_cnt;
                end
            end else if (in_cyc) begin
                in_cyc = 0;
                last_end[bank] = cyc;
                if (exp_q.size() == 0) begin
                    check(0, "R4", "unexpected select cycle", bank, -1);
                end else begin
                    it = exp_q.pop_front();
                    check(bank == it.bank, it.req, "bank selected", bank, it.bank);
                    check(s_cnt == it.s, "R5", "setup clocks", s_cnt, it.s);
                    check(a_cnt == it.a, "R6", "strobe clocks", a_cnt, it.a);
                    check(acks == 1, "R6", "ack count", acks, 1);
                    check(ack_at == it.a, "R6", "ack in last strobe clock", ack_at, it.a);
                    check(h_cnt == it.h, "R7", "hold clocks", h_cnt, it.h);
                    check(saw_wr == it.wr, "R8", "strobe kind", int'(saw_wr), int'(it.wr));
                end
            end
        end
    end

    task automatic summary();
        $display("%0d/%0d checks passed", checks - fails, checks);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: run did not finish, actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        check(cs_n == 8'hFF && rd_n && wr_n && !bus_ack, "R1", "outputs in reset",
              int'(cs_n), 255);
        rst = 1'b0;
        @(negedge clk);
        check(cs_n == 8'hFF && rd_n && wr_n && !bus_ack, "R1", "outputs after reset",
              int'(cs_n), 255);

        // R1: boot bank 0, 8 Mbytes at zero, default timing; recovery 1 -> gap >= 2
        do_cycle(32'h0000100, 0, 0, 1, 4, 1, 0, "R1", 0);
        do_cycle(32'h07FFFFE, 1, 0, 1, 4, 1, 2, "R1", 0);
        miss_cycle(32'h0800000, "R1");

        // R2/R8: bank 1, 256 Kbytes at 0x1000000; zero read timing, long write timing
        write_cfg(1, mk_cfg(1, 0, 32'h1000000, 0, 0, 0, 0, 2, 3, 2, 0));
        do_cycle(32'h1000004, 0, 1, 0, 0, 0, 0, "R2", 0);
        do_cycle(32'h103FFFE, 1, 1, 2, 3, 2, 0, "R8", 0);
        miss_cycle(32'h1040000, "R2");

        // R2: 64 Mbyte bank 2 at 0x4000000
        write_cfg(2, mk_cfg(1, 7, 32'h4000000, 1, 2, 0, 0, 1, 2, 0, 0));
        do_cycle(32'h7FFFFFE, 0, 2, 1, 2, 0, 0, "R2", 0);

        // R3: overlapping banks, the lower number wins
        write_cfg(3, mk_cfg(1, 0, 32'h4000000, 0, 1, 0, 0, 0, 1, 0, 0));
        write_cfg(4, mk_cfg(1, 0, 32'h0000000, 0, 1, 0, 0, 0, 1, 0, 0));
        do_cycle(32'h4000010, 0, 2, 1, 2, 0, 0, "R3", 0);
        do_cycle(32'h0000010, 0, 0, 1, 4, 1, 0, "R3", 0);

        // R4: a disabled bank no longer answers
        write_cfg(1, mk_cfg(0, 0, 32'h1000000, 0, 0, 0, 0, 2, 3, 2, 0));
        miss_cycle(32'h1000004, "R4");

        // R9: recovery 5 on bank 5 forces at least 6 idle select clocks
        write_cfg(5, mk_cfg(1, 0, 32'h8000000, 0, 1, 0, 5, 0, 1, 0, 5));
        do_cycle(32'h8000000, 0, 5, 0, 1, 0, 0, "R9", 0);
        do_cycle(32'h8000002, 0, 5, 0, 1, 0, 6, "R9", 0);
        do_cycle(32'h8000004, 1, 5, 0, 1, 0, 6, "R9", 0);

        // R10: request held after acknowledge does not start a second cycle
        write_cfg(6, mk_cfg(1, 0, 32'h8040000, 0, 1, 0, 0, 0, 1, 0, 0));
        do_cycle(32'h8040000, 0, 6, 0, 1, 0, 0, "R10", 12);
        do_cycle(32'h8040004, 0, 6, 0, 1, 0, 0, "R10", 0);

        repeat (20) @(negedge clk);
        check(exp_q.size() == 0, "R6", "expected cycles left unseen", exp_q.size(), 0);
        summary();
        $finish;
    end

endmodule